// File: doc/BRIEF.md
# Trigger Pulse Regenerator

This block turns a raw trigger line into a clean output pulse for one channel of a pulse-repeater board clocked at 20 MHz. The trigger can take one of two paths, chosen by an active-low filter-enable input. With the filter bypassed the path is purely combinational: the output follows the trigger with no clocked delay and no jitter, but it reacts to glitches. With the filter enabled the trigger is synchronised and must hold a new level for a set number of clock cycles before it is accepted. It then passes through a short alignment pipe, which gives a fixed latency with one cycle of jitter against the asynchronous input.

A build option selects the output shape. In fixed-width mode every accepted rising edge produces a pulse of exactly `PWIDTH` cycles, whatever the length of the trigger. In level mode the output follows the selected trigger level. In both modes a guard window of `PWIDTH * DUTY_DIV` cycles opens at each accepted edge, which caps the duty cycle at 1/`DUTY_DIV`. A rising edge that arrives inside that window starts nothing and is reported on a one-cycle error strobe. The enable input gates both the output and the acceptance of edges.

Top module: `pulse_regen`

## Requirements
- R1: While `rst_ni` is low, `pulse_o` and `err_o` are low whatever the trigger does. Reset clears the filter, the alignment pipe, the guard counter and the error strobe.
- R2: With `filt_en_ni` high (filter bypassed), a rising trigger that is accepted drives `pulse_o` high in the same cycle, before any clock edge.
- R3: With `FIXED_WIDTH` = 1, each accepted rising edge gives a `pulse_o` high time of exactly `PWIDTH` cycles, counting the cycle of the edge. This holds for a trigger shorter or longer than `PWIDTH`.
- R4: With `filt_en_ni` low, suppose the first clock edge that samples the trigger high is edge k and the trigger stays high long enough. Then `pulse_o` rises just after edge k + `GF_LEN` + 5.
- R5: With the filter enabled, a trigger that is high for fewer than `GF_LEN` consecutive clock samples produces no output at all. A trigger high for exactly `GF_LEN` samples is accepted.
- R6: An accepted edge opens a guard window of P = `PWIDTH * DUTY_DIV` cycles. A rising edge seen by the pulse engine 1 to P-1 cycles later is rejected: it gives no pulse and does not restart the window. An edge P or more cycles later is accepted.
- R7: Each rejected rising edge raises `err_o` for exactly one cycle, the cycle after the edge reaches the pulse engine. Accepted edges never raise `err_o`.
- R8: While `en_i` is low, `pulse_o` is low, no edge is accepted, no window opens and `err_o` stays low. An edge right after `en_i` returns high is accepted.
- R9: With `FIXED_WIDTH` = 0, `pulse_o` follows the selected trigger level (raw, or filtered and aligned) while enabled. Guard windows and the error strobe still work as in R6 and R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Channel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Channel enable, active high |
| filt_en_ni | input | 1 | Glitch-filter enable, active low (high = bypass) |
| trig_i | input | 1 | Asynchronous trigger input |
| pulse_o | output | 1 | Regenerated pulse output |
| err_o | output | 1 | One-cycle strobe for a trigger rejected by the guard window |

## Verification
The checker takes for granted that `en_i` and `filt_en_ni` change only while the channel is idle. It also assumes that a fixed-width pulse is not cut short by a drop of enable, since the width check skips any pulse during which enable went low. The trigger is treated as a level that stays put between edges. The bench therefore drives every input on the falling clock edge and changes mode and enable only after an idle gap longer than the guard window. In filtered runs it keeps trigger highs and lows at least `GF_LEN` samples long, except in the deliberate glitch sweep.

// File: rtl/pr_regen_pkg.sv
package pr_regen_pkg;

  // Registers between the filtered level and the edge detector, chosen so
  // that filtered latency is GF_LEN + 5 clock edges.
  localparam int unsigned PR_ALIGN_STAGES = 4;

  // Length of one guard window in clock cycles.
  function automatic int unsigned pr_period(int unsigned width, int unsigned div);
    return width * div;
  endfunction

  // True while a down-counting window is still in its high phase.
  function automatic logic pr_high_phase(int unsigned cnt, int unsigned period,
                                         int unsigned width);
    return (cnt + width) > period;
  endfunction

  // Edges from first high sample to visible output in filtered mode.
  function automatic int unsigned pr_filt_latency(int unsigned gf_len);
    return gf_len + 1 + PR_ALIGN_STAGES;
  endfunction

endpackage

// File: rtl/pr_trig_front.sv
module pr_trig_front
  import pr_regen_pkg::*;
#(
  parameter int unsigned GF_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bypass_i,
  input  logic trig_i,
  output logic src_lvl_o,
  output logic rise_o
);
  localparam int unsigned FCW = (GF_LEN < 2) ? 1 : $clog2(GF_LEN + 1);
  localparam int unsigned AS  = PR_ALIGN_STAGES;

  logic           sync1_q, sync2_q, filt_q, src_q;
  logic [FCW-1:0] fcnt_q;
  logic           aligned_w;

  // two-flop synchroniser and stability filter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      filt_q  <= 1'b0;
      fcnt_q  <= '0;
      src_q   <= 1'b0;
    end else begin
      sync1_q <= trig_i;
      sync2_q <= sync1_q;
      src_q   <= src_lvl_o;
      if (sync2_q == filt_q) begin
        fcnt_q <= '0;
      end else if (fcnt_q == FCW'(GF_LEN - 1)) begin
        filt_q <= sync2_q;
        fcnt_q <= '0;
      end else begin
        fcnt_q <= fcnt_q + 1'b1;
      end
    end
  end

  // alignment pipe after the filter
  for (genvar g = 0; g < AS; g++) begin : g_align
    logic stage_q;
    logic stage_d;
    if (g == 0) begin : g_head
      assign stage_d = filt_q;
    end else begin : g_tail
      assign stage_d = g_align[g-1].stage_q;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q <= 1'b0;
      else         stage_q <= stage_d;
    end
  end

  assign aligned_w = g_align[AS-1].stage_q;
  assign src_lvl_o = bypass_i ? trig_i : aligned_w;
  assign rise_o    = src_lvl_o & ~src_q;

endmodule

// File: rtl/pr_pulse_engine.sv
module pr_pulse_engine
  import pr_regen_pkg::*;
#(
  parameter int unsigned PWIDTH   = 24,
  parameter int unsigned DUTY_DIV = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic rise_i,
  output logic start_o,
  output logic busy_o,
  output logic hold_o,
  output logic err_o
);
  localparam int unsigned PERIOD = pr_period(PWIDTH, DUTY_DIV);
  localparam int unsigned CW     = $clog2(PERIOD + 1);

  logic [CW-1:0] pcnt_q;
  logic          err_q;
  logic          reject_w;

  assign busy_o   = (pcnt_q != '0);
  assign start_o  = rst_ni & en_i & rise_i & ~busy_o;
  assign reject_w = rst_ni & en_i & rise_i & busy_o;
  assign hold_o   = pr_high_phase(32'(pcnt_q), PERIOD, PWIDTH);
  assign err_o    = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= reject_w;
      if (start_o)     pcnt_q <= CW'(PERIOD - 1);
      else if (busy_o) pcnt_q <= pcnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/pulse_regen.sv
module pulse_regen
  import pr_regen_pkg::*;
#(
  parameter bit          FIXED_WIDTH = 1'b1,
  parameter int unsigned PWIDTH      = 24,
  parameter int unsigned DUTY_DIV    = 5,
  parameter int unsigned GF_LEN      = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic filt_en_ni,
  input  logic trig_i,
  output logic pulse_o,
  output logic err_o
);
  logic src_lvl_w, rise_w, start_w, busy_w, hold_w, shape_w;

  pr_trig_front #(.GF_LEN(GF_LEN)) u_front (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bypass_i  (filt_en_ni),
    .trig_i    (trig_i),
    .src_lvl_o (src_lvl_w),
    .rise_o    (rise_w)
  );

  pr_pulse_engine #(.PWIDTH(PWIDTH), .DUTY_DIV(DUTY_DIV)) u_engine (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .rise_i  (rise_w),
    .start_o (start_w),
    .busy_o  (busy_w),
    .hold_o  (hold_w),
    .err_o   (err_o)
  );

  always_comb begin
    if (FIXED_WIDTH) shape_w = start_w | hold_w;
    else             shape_w = src_lvl_w;
  end

  assign pulse_o = rst_ni & en_i & shape_w;

endmodule

// File: rtl/pr_regen_chk.sv
module pr_regen_chk
  import pr_regen_pkg::*;
#(
  parameter bit          FIXED_WIDTH = 1'b1,
  parameter int unsigned PWIDTH      = 24,
  parameter int unsigned DUTY_DIV    = 5
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic pulse_o,
  input logic err_o,
  input logic busy_w,
  input logic start_w
);
  localparam int unsigned PERIOD = pr_period(PWIDTH, DUTY_DIV);
  localparam int unsigned CW     = $clog2(PERIOD + 1);

  logic [CW-1:0] gap_q;
  logic [31:0]   run_q;
  logic          seen_q, en_gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q    <= '0;
      run_q    <= '0;
      seen_q   <= 1'b0;
      en_gap_q <= 1'b0;
    end else begin
      if (start_w) begin
        gap_q  <= CW'(1);
        seen_q <= 1'b1;
      end else if (gap_q < CW'(PERIOD)) begin
        gap_q <= gap_q + 1'b1;
      end
      run_q    <= pulse_o ? run_q + 1 : '0;
      en_gap_q <= start_w ? 1'b0 : (en_gap_q | ~en_i);
    end
  end

  // R1: outputs quiet while reset is held
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert (!pulse_o && !err_o);
    end
  end

  always @(posedge clk_i) begin
    if (rst_ni) begin
      // R6: accepted edges are at least one guard window apart
      if (start_w && seen_q) begin
        p_guard_window_r6: assert (gap_q >= CW'(PERIOD));
      end
      // R3: a fixed-width pulse that enable did not cut lasts PWIDTH cycles
      if (FIXED_WIDTH && !pulse_o && run_q != 0 && en_i && !en_gap_q) begin
        p_fixed_width_r3: assert (run_q == 32'(PWIDTH));
      end
    end
  end

  p_err_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  p_err_in_window_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(busy_w));

  p_enable_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !pulse_o);

endmodule

bind pulse_regen pr_regen_chk #(
  .FIXED_WIDTH (FIXED_WIDTH),
  .PWIDTH      (PWIDTH),
  .DUTY_DIV    (DUTY_DIV)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .pulse_o (pulse_o),
  .err_o   (err_o),
  .busy_w  (busy_w),
  .start_w (start_w)
);

// File: tb/pulse_regen_tb_top.sv
module pulse_regen_tb_top;
  localparam int PW   = 20;
  localparam int DV   = 3;
  localparam int GF   = 3;
  localparam int PER  = PW * DV;
  localparam int LAT  = GF + 6;   // index offset of filtered output vs. drive
  localparam int WIN  = 150;

  logic clk = 1'b0;
  logic rst_n = 1'b0, en = 1'b0, filt_n = 1'b1, trig = 1'b0;
  logic p_fx, e_fx, p_lv, e_lv;

  pulse_regen #(.FIXED_WIDTH(1'b1), .PWIDTH(PW), .DUTY_DIV(DV), .GF_LEN(GF)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .filt_en_ni(filt_n), .trig_i(trig),
    .pulse_o(p_fx), .err_o(e_fx));

  pulse_regen #(.FIXED_WIDTH(1'b0), .PWIDTH(PW), .DUTY_DIV(DV), .GF_LEN(GF)) dut_lvl_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .filt_en_ni(filt_n), .trig_i(trig),
    .pulse_o(p_lv), .err_o(e_lv));

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  int fx_first, fx_cnt, lv_first, lv_cnt, er_first, er_cnt, er2_cnt;

  task automatic chk_eq(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit in_win(int i, int s, int len);
    return (s >= 0) && (i >= s) && (i < s + len);
  endfunction

  task automatic capture(int s0, int s1, int s2, int len, int idle);
    fx_first = -1; lv_first = -1; er_first = -1;
    fx_cnt = 0; lv_cnt = 0; er_cnt = 0; er2_cnt = 0;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      trig = in_win(i, s0, len) | in_win(i, s1, len) | in_win(i, s2, len);
      #1;
      if (p_fx) begin if (fx_first < 0) fx_first = i; fx_cnt++; end
      if (p_lv) begin if (lv_first < 0) lv_first = i; lv_cnt++; end
      if (e_fx) begin if (er_first < 0) er_first = i; er_cnt++; end
      if (e_lv) er2_cnt++;
    end
    @(negedge clk);
    trig = 1'b0;
    for (int j = 0; j < idle; j++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset holds outputs low even with a raw trigger present
    en = 1'b1; filt_n = 1'b1; trig = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk_eq("R1 pulse fixed in reset", int'(p_fx), 0);
    chk_eq("R1 pulse level in reset", int'(p_lv), 0);
    chk_eq("R1 err in reset", int'(e_fx), 0);
    @(negedge clk); trig = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R2 R3 R9: bypass, short trigger
    capture(0, -1, -1, 5, 100);
    chk_eq("R2 first index fixed", fx_first, 0);
    chk_eq("R3 width short trig", fx_cnt, PW);
    chk_eq("R9 level follows raw", lv_cnt, 5);
    chk_eq("R9 level first index", lv_first, 0);
    chk_eq("R7 no err on accept", er_cnt, 0);

    // R3 R9: bypass, long trigger
    capture(0, -1, -1, 45, 100);
    chk_eq("R3 width long trig", fx_cnt, PW);
    chk_eq("R9 level long trig", lv_cnt, 45);

    // R6 R7 R9: bypass, retrigger inside then at window end
    capture(0, 30, PER, 5, 100);
    chk_eq("R6 two pulses only", fx_cnt, 2 * PW);
    chk_eq("R7 one err", er_cnt, 1);
    chk_eq("R7 err index", er_first, 31);
    chk_eq("R9 level count", lv_cnt, 15);
    chk_eq("R9 level err", er2_cnt, 1);

    // R6 R7: boundary sweep of retrigger offset
    for (int r = PER - 2; r <= PER + 1; r++) begin
      capture(0, r, -1, 1, 100);
      chk_eq($sformatf("R6 count off=%0d", r), fx_cnt, (r >= PER) ? 2 * PW : PW);
      chk_eq($sformatf("R7 err off=%0d", r), er_cnt, (r >= PER) ? 0 : 1);
      if (r < PER) chk_eq($sformatf("R7 err idx off=%0d", r), er_first, r + 1);
    end

    // R4 R9: filtered path latency
    filt_n = 1'b0;
    capture(0, -1, -1, 5, 100);
    chk_eq("R4 filtered first fixed", fx_first, LAT);
    chk_eq("R4 filtered width", fx_cnt, PW);
    chk_eq("R9 filtered level first", lv_first, LAT);
    chk_eq("R9 filtered level count", lv_cnt, 5);

    // R5: glitch length sweep
    for (int h = 1; h <= GF + 2; h++) begin
      capture(0, -1, -1, h, 100);
      chk_eq($sformatf("R5 fixed hold=%0d", h), fx_cnt, (h >= GF) ? PW : 0);
      chk_eq($sformatf("R5 level hold=%0d", h), lv_cnt, (h >= GF) ? h : 0);
    end

    // R6 R7: filtered retrigger
    capture(0, 30, PER, 5, 100);
    chk_eq("R6 filtered pulses", fx_cnt, 2 * PW);
    chk_eq("R6 filtered first", fx_first, LAT);
    chk_eq("R7 filtered err idx", er_first, 30 + LAT + 1);
    chk_eq("R7 filtered err count", er_cnt, 1);

    // R8: enable low blocks pulse, error and window
    filt_n = 1'b1;
    en = 1'b0;
    capture(0, 30, 140, 5, 0);
    chk_eq("R8 no pulse fixed", fx_cnt, 0);
    chk_eq("R8 no pulse level", lv_cnt, 0);
    chk_eq("R8 no err", er_cnt + er2_cnt, 0);
    en = 1'b1;
    capture(0, -1, -1, 5, 100);
    chk_eq("R8 accepted after enable", fx_cnt, PW);
    chk_eq("R8 no err after enable", er_cnt, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule